// File: doc/BRIEF.md
# DDR Read Burst Truncation Scheduler

This block sits in the command path of a DDR SDRAM controller. It handles one READ at a time. It takes a READ request with a target bank, the number of data pairs wanted and two flags. One flag chooses how the read is closed: by a BURST TERMINATE or by a PRECHARGE of the same bank. The other flag enables auto precharge. The block puts the READ on the command bus. It then counts cycles in two-element data pairs and puts the closing command on the bus at the matching cycle. When the full burst is wanted, no terminate is sent and the burst simply runs out.

A pending WRITE is held back while the read is open. It is also held back for a turnaround window after the read closes. Every bank has its own row precharge countdown. The countdown starts on an explicit PRECHARGE, or on the close of a READ that carried auto precharge. No READ or WRITE to that bank leaves the block before the countdown expires. Commands appear on the bus as one-cycle valid pulses. Any request that cannot be carried out is reported with an error pulse and issues nothing.

Top module: `ddr_rd_trunc_sched`

## Requirements
- R1: While reset is held, and after it is released, `cmd_valid_o` and `err_o` are low, `rd_ready_o` is high and every bit of `bank_idle_o` is high.
- R2: The READ request is sampled on a clock edge and accepted at that edge. The READ command (code 0) appears on `cmd_o` with its bank in the cycle after that edge. From that cycle `rd_ready_o` stays low until the read closes.
- R3: Take a read with close mode terminate (`rd_pre_i`=0) and x pairs, where 1 <= x < BURST_LEN/2. A BURST TERMINATE (code 2) on the same bank appears exactly x cycles after the READ cycle. `rd_ready_o` goes high in that same cycle.
- R4: Take a read with close mode terminate and x = BURST_LEN/2. No command is issued when it closes. `rd_ready_o` goes high x cycles after the READ cycle.
- R5: Take a read with close mode precharge (`rd_pre_i`=1, `rd_ap_i`=0) and any x from 1 to BURST_LEN/2. A PRECHARGE (code 3) on the same bank appears exactly x cycles after the READ cycle.
- R6: A request is rejected when any of these holds while `rd_ready_o` is high: both `rd_pre_i` and `rd_ap_i` are set, or x = 0, or x > BURST_LEN/2. A rejected request gives a one-cycle `err_o` pulse in the following cycle. It issues no READ and no closing command, and `rd_ready_o` stays high.
- R7: A WRITE (code 1) is never issued while a read is open. It is never issued earlier than CAS_LAT+1 cycles after the cycle in which the read closed. If `wr_req_i` is held and its bank is idle, the WRITE appears exactly then.
- R8: Take a PRECHARGE of bank b in cycle P. Then `bank_idle_o[b]` is low from cycle P through cycle P+T_RP-2, and the earliest READ or WRITE to bank b appears in cycle P+T_RP.
- R9: A read with `rd_ap_i`=1 issues no PRECHARGE. Bank b still follows the same countdown as in R8, with P taken as the cycle in which the read closes.
- R10: Suppose a READ is accepted at an edge where a WRITE would also be eligible. The READ is issued and the WRITE waits.
- R11: A READ request sampled while `rd_ready_o` is low is ignored: it produces no command and no `err_o`.
- R12: A valid READ request to a bank whose `bank_idle_o` bit is low is ignored: it produces no command and no `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | READ request, sampled each edge |
| rd_bank_i | input | BANK_W | Bank of the READ |
| rd_pairs_i | input | PAIR_W | Data pairs wanted, 1 to BURST_LEN/2 |
| rd_pre_i | input | 1 | Close mode: 1 = precharge, 0 = terminate |
| rd_ap_i | input | 1 | Auto precharge enabled on the READ |
| wr_req_i | input | 1 | WRITE request, held until the WRITE is seen |
| wr_bank_i | input | BANK_W | Bank of the WRITE |
| rd_ready_o | output | 1 | No read open; a READ request can be taken |
| bank_idle_o | output | NUM_BANKS | Per bank: a command sampled now may be issued |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_o | output | 2 | Command code: 0 READ, 1 WRITE, 2 BURST TERMINATE, 3 PRECHARGE |
| cmd_bank_o | output | BANK_W | Bank of the command |
| err_o | output | 1 | One-cycle pulse for a rejected READ request |

## Verification
Two things can land on the same edge. One is the handling of a new READ request, which may be accepted or rejected. The other is the grant of a pending WRITE. The bench holds a WRITE request pending and issues a READ request on the same edge, in both directed and random cases. An accepted read must win, and the WRITE must then wait until the read closes plus CAS_LAT+1 cycles. A rejected read must give its error pulse in the same cycle as the WRITE it let through. A cycle-level reference model in the bench judges every cycle, comparing the command, bank, error, ready and bank-idle outputs.

// File: rtl/ddr_trunc_pkg.sv
package ddr_trunc_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_BST   = 2'd2,
    CMD_PRE   = 2'd3
  } cmd_e;
endpackage

// File: rtl/ddr_bank_timers.sv
module ddr_bank_timers #(
  parameter int NUM_BANKS = 4,
  parameter int T_RP      = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] load_i,
  output logic [NUM_BANKS-1:0] idle_o
);
  localparam int RP_W = $clog2(T_RP + 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [RP_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (load_i[b])      cnt_q <= RP_W'(T_RP - 1);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign idle_o[b] = (cnt_q == '0);

    // a bank is only closed after a read that was accepted while it was idle
    a_r8_load_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i[b] |-> idle_o[b]);
  end
endmodule

// File: rtl/ddr_rd_tracker.sv
module ddr_rd_tracker #(
  parameter int BANK_W    = 2,
  parameter int PAIR_W    = 3,
  parameter int MAX_PAIRS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [PAIR_W-1:0] pairs_i,
  input  logic              pre_i,
  input  logic              ap_i,
  output logic              busy_o,
  output logic              close_o,
  output logic              close_bst_o,
  output logic              close_pre_o,
  output logic              close_rp_o,
  output logic [BANK_W-1:0] bank_o
);
  logic              busy_q, pre_q, ap_q, full_q;
  logic [PAIR_W-1:0] cnt_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= '0;
      pre_q  <= 1'b0;
      ap_q   <= 1'b0;
      full_q <= 1'b0;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      cnt_q  <= pairs_i;
      bank_q <= bank_i;
      pre_q  <= pre_i;
      ap_q   <= ap_i;
      full_q <= (pairs_i == PAIR_W'(MAX_PAIRS));
    end else if (busy_q) begin
      if (cnt_q == PAIR_W'(1)) busy_q <= 1'b0;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o      = busy_q;
  assign close_o     = busy_q && (cnt_q == PAIR_W'(1));
  assign close_bst_o = close_o && !pre_q && !full_q;
  assign close_pre_o = close_o && pre_q;
  assign close_rp_o  = close_o && (pre_q || ap_q);
  assign bank_o      = bank_q;

  a_r11_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !busy_q);
  a_r2_open_count_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q != '0);
  a_r6_no_pre_on_ap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_pre_o |-> !ap_q);
  a_r3_close_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_o |=> !busy_q);
endmodule

// File: rtl/ddr_wr_gate.sv
module ddr_wr_gate #(
  parameter int CAS_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic close_i,
  output logic ta_ok_o
);
  localparam int TA_W = $clog2(CAS_LAT + 2);

  logic [TA_W-1:0] ta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ta_q <= '0;
    else if (close_i)     ta_q <= TA_W'(CAS_LAT);
    else if (ta_q != '0)  ta_q <= ta_q - 1'b1;
  end

  assign ta_ok_o = (ta_q == '0);

  if (CAS_LAT > 0) begin : g_ta_chk
    a_r7_turnaround_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      close_i |=> !ta_ok_o);
  end
endmodule

// File: rtl/ddr_rd_trunc_sched.sv
module ddr_rd_trunc_sched
  import ddr_trunc_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 8,
  parameter int CAS_LAT   = 2,
  parameter int T_RP      = 3,
  localparam int MAX_PAIRS = BURST_LEN / 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int PAIR_W    = $clog2(MAX_PAIRS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_req_i,
  input  logic [BANK_W-1:0]    rd_bank_i,
  input  logic [PAIR_W-1:0]    rd_pairs_i,
  input  logic                 rd_pre_i,
  input  logic                 rd_ap_i,
  input  logic                 wr_req_i,
  input  logic [BANK_W-1:0]    wr_bank_i,
  output logic                 rd_ready_o,
  output logic [NUM_BANKS-1:0] bank_idle_o,
  output logic                 cmd_valid_o,
  output logic [1:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic                 err_o
);
  logic              busy, close, close_bst, close_pre, close_rp, ta_ok;
  logic [BANK_W-1:0] trk_bank;
  logic [NUM_BANKS-1:0] idle, rp_load;
  logic              rd_try, rd_ok, rd_bad, accept, wr_fire;

  assign rd_try  = rd_req_i && !busy;
  assign rd_ok   = (rd_pairs_i != '0) && (rd_pairs_i <= PAIR_W'(MAX_PAIRS))
                   && !(rd_pre_i && rd_ap_i);
  assign rd_bad  = rd_try && !rd_ok;
  assign accept  = rd_try && rd_ok && idle[rd_bank_i];
  // read acceptance has priority over a pending write
  assign wr_fire = wr_req_i && !busy && ta_ok && idle[wr_bank_i] && !accept;

  ddr_rd_tracker #(
    .BANK_W(BANK_W), .PAIR_W(PAIR_W), .MAX_PAIRS(MAX_PAIRS)
  ) u_trk (
    .clk_i, .rst_ni,
    .accept_i(accept), .bank_i(rd_bank_i), .pairs_i(rd_pairs_i),
    .pre_i(rd_pre_i), .ap_i(rd_ap_i),
    .busy_o(busy), .close_o(close), .close_bst_o(close_bst),
    .close_pre_o(close_pre), .close_rp_o(close_rp), .bank_o(trk_bank)
  );

  ddr_wr_gate #(.CAS_LAT(CAS_LAT)) u_wr (
    .clk_i, .rst_ni, .close_i(close), .ta_ok_o(ta_ok)
  );

  always_comb begin
    rp_load = '0;
    if (close_rp) rp_load[trk_bank] = 1'b1;
  end

  ddr_bank_timers #(.NUM_BANKS(NUM_BANKS), .T_RP(T_RP)) u_rp (
    .clk_i, .rst_ni, .load_i(rp_load), .idle_o(idle)
  );

  logic              cmd_valid_q, err_q;
  cmd_e              cmd_q;
  logic [BANK_W-1:0] cmd_bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_q <= 1'b0;
      cmd_q       <= CMD_READ;
      cmd_bank_q  <= '0;
      err_q       <= 1'b0;
    end else begin
      err_q       <= rd_bad;
      cmd_valid_q <= accept || wr_fire || close_bst || close_pre;
      if (accept) begin
        cmd_q      <= CMD_READ;
        cmd_bank_q <= rd_bank_i;
      end else if (wr_fire) begin
        cmd_q      <= CMD_WRITE;
        cmd_bank_q <= wr_bank_i;
      end else if (close_bst) begin
        cmd_q      <= CMD_BST;
        cmd_bank_q <= trk_bank;
      end else if (close_pre) begin
        cmd_q      <= CMD_PRE;
        cmd_bank_q <= trk_bank;
      end
    end
  end

  assign rd_ready_o  = !busy;
  assign bank_idle_o = idle;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_o       = cmd_q;
  assign cmd_bank_o  = cmd_bank_q;
  assign err_o       = err_q;

  a_r10_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({accept, wr_fire, close_bst, close_pre}));
  a_r7_no_write_after_bst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_BST) |=> !(cmd_valid_o && cmd_o == CMD_WRITE));
  a_r6_err_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(cmd_valid_o && cmd_o == CMD_READ));
  a_r2_read_holds_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_o && cmd_o == CMD_READ) |-> !rd_ready_o);

  if (T_RP > 1) begin : g_rp_chk
    a_r8_bank_quiet_after_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_o && cmd_o == CMD_PRE)
      |=> !(cmd_valid_o && cmd_bank_o == $past(cmd_bank_o)));
  end
endmodule

// File: tb/tb_ddr_rd_trunc_sched.sv
`timescale 1ns/1ps
module tb_ddr_rd_trunc_sched;
  localparam int NB   = 4;
  localparam int BL   = 8;
  localparam int CL   = 2;
  localparam int TRP  = 3;
  localparam int MAXP = BL / 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rd_req = 1'b0, rd_pre = 1'b0, rd_ap = 1'b0, wr_req = 1'b0;
  logic [1:0] rd_bank = '0, wr_bank = '0;
  logic [2:0] rd_pairs = '0;
  logic       rd_ready, cmd_valid, err;
  logic [3:0] bank_idle;
  logic [1:0] cmd, cmd_bank;

  always #4 clk = ~clk;

  ddr_rd_trunc_sched #(.NUM_BANKS(NB), .BURST_LEN(BL), .CAS_LAT(CL), .T_RP(TRP)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .rd_req_i(rd_req), .rd_bank_i(rd_bank), .rd_pairs_i(rd_pairs),
    .rd_pre_i(rd_pre), .rd_ap_i(rd_ap),
    .wr_req_i(wr_req), .wr_bank_i(wr_bank),
    .rd_ready_o(rd_ready), .bank_idle_o(bank_idle),
    .cmd_valid_o(cmd_valid), .cmd_o(cmd), .cmd_bank_o(cmd_bank), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  string tag_ovr = "";

  // reference model state
  int  c = 0;
  bit  act = 0;
  int  close_c = 0, r_bank = 0, r_x = 0;
  bit  r_pre = 0, r_ap = 0;
  int  ta_ok = 0;
  int  bank_ok [NB];
  bit  e_v, e_err, e_rdy;
  int  e_cmd, e_bank;
  logic [3:0] e_idle;

  task automatic chk(input string tag, input int actual, input int expv);
    string t;
    t = (tag_ovr != "") ? tag_ovr : tag;
    n_chk++;
    if (actual != expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d: got %0d expected %0d", t, c, actual, expv);
    end
  endtask

  function automatic string cmd_tag(input bit v, input int code);
    if (!v) return "R4";
    case (code)
      0: return "R2";
      1: return "R7";
      2: return "R3";
      default: return "R5";
    endcase
  endfunction

  function automatic bit bad_req(input int px, input bit pr, input bit ap);
    return (px == 0) || (px > MAXP) || (pr && ap);
  endfunction

  // expected outputs for the edge numbered c, from inputs currently driven
  task automatic model();
    bit rd_go;
    e_v = 0; e_cmd = 0; e_bank = 0; e_err = 0; rd_go = 0;
    if (act && close_c == c) begin
      if (r_pre) begin e_v = 1; e_cmd = 3; e_bank = r_bank; end
      else if (r_x < MAXP) begin e_v = 1; e_cmd = 2; e_bank = r_bank; end
      act = 0;
      ta_ok = c + CL + 1;
      if (r_pre || r_ap) bank_ok[r_bank] = c + TRP;
    end else if (!act) begin
      if (rd_req) begin
        if (bad_req(int'(rd_pairs), rd_pre, rd_ap)) e_err = 1;
        else if (bank_ok[rd_bank] <= c) begin
          rd_go = 1; e_v = 1; e_cmd = 0; e_bank = int'(rd_bank);
          act = 1; close_c = c + int'(rd_pairs);
          r_bank = int'(rd_bank); r_x = int'(rd_pairs); r_pre = rd_pre; r_ap = rd_ap;
        end
      end
      if (!rd_go && wr_req && c >= ta_ok && bank_ok[wr_bank] <= c) begin
        e_v = 1; e_cmd = 1; e_bank = int'(wr_bank);
      end
    end
    e_rdy = !(act && close_c > c);
    for (int b = 0; b < NB; b++) e_idle[b] = (bank_ok[b] <= c + 1);
  endtask

  task automatic cyc(input bit rq, input int bk, input int px, input bit pr, input bit ap);
    string t;
    rd_req = rq; rd_bank = 2'(bk); rd_pairs = 3'(px); rd_pre = pr; rd_ap = ap;
    c++;
    model();
    @(posedge clk);
    @(negedge clk);
    t = cmd_tag(e_v, e_cmd);
    chk(t, int'(cmd_valid), int'(e_v));
    if (e_v) begin
      chk(t, int'(cmd), e_cmd);
      chk(t, int'(cmd_bank), e_bank);
    end
    chk("R6", int'(err), int'(e_err));
    chk("R2", int'(rd_ready), int'(e_rdy));
    chk("R8", int'(bank_idle), int'(e_idle));
    if (cmd_valid && cmd == 2'd1) wr_req = 1'b0;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) bank_ok[b] = 0;
    void'($urandom(32'h0d0e_5eed));
    repeat (3) @(negedge clk);
    // R1: reset state
    tag_ovr = "R1";
    chk("R1", int'(cmd_valid), 0);
    chk("R1", int'(err), 0);
    chk("R1", int'(rd_ready), 1);
    chk("R1", int'(bank_idle), 15);
    rst_ni = 1'b1;
    idle_n(2);

    // R10 + R3 + R7: write pending on bank0 while a 2-pair terminated read to bank1 starts
    tag_ovr = "R10";
    wr_req = 1; wr_bank = 0;
    cyc(1, 1, 2, 0, 0);
    tag_ovr = "";
    idle_n(8);

    // R4: full burst, no terminate
    cyc(1, 2, MAXP, 0, 0);
    idle_n(7);

    // R5 + R12: precharge after one pair, then hammer bank2 with reads
    cyc(1, 2, 1, 1, 0);
    tag_ovr = "R12";
    for (int i = 0; i < 5; i++) cyc(1, 2, 1, 0, 0);
    tag_ovr = "";
    idle_n(6);

    // R5: precharge at full length
    cyc(1, 0, MAXP, 1, 0);
    idle_n(7);

    // R6: rejections, one with a write granted in the same cycle
    tag_ovr = "R6";
    wr_req = 1; wr_bank = 3;
    cyc(1, 1, 2, 1, 1);
    cyc(1, 1, 0, 0, 0);
    cyc(1, 1, MAXP + 1, 0, 0);
    tag_ovr = "";
    idle_n(2);

    // R9: auto precharge read on bank3, then a write to bank3 waits for the countdown
    tag_ovr = "R9";
    cyc(1, 3, 3, 0, 1);
    wr_req = 1; wr_bank = 3;
    idle_n(9);

    // R11: requests while busy are ignored
    tag_ovr = "R11";
    cyc(1, 0, 4, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 1, 0);
    tag_ovr = "";
    idle_n(6);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if (!wr_req && ($urandom % 3 == 0)) begin
        wr_req = 1; wr_bank = 2'($urandom % NB);
      end
      cyc(($urandom % 4) == 0, $urandom % NB, $urandom % 6,
          ($urandom % 2) == 1, ($urandom % 4) == 0);
    end
    wr_req = 0;
    idle_n(10);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule